// File: doc/BRIEF.md
# Five-Times Oversampled Bit Recovery Lane

Some serial links run below the lowest rate a transceiver can lock to. In that case the transceiver is clocked at five times the real bit rate, so every line bit shows up as five equal samples in its parallel output. This block turns that sample stream back into real link data. For each group of five samples it keeps the middle sample. It packs the bits it recovers into words as wide as the transceiver word, and it marks each finished word with a one-cycle write strobe for a downstream dual-clock FIFO.

All colour lanes share one phase counter. Each lane has its own extraction and packing path, and the number of lanes is a parameter. A mode input picks either oversampled extraction or bypass. In bypass, every transceiver word is registered straight to the output and the write strobe stays high. Clock-domain crossing and symbol decoding are done downstream.

Top module: `osx_extract`

## Requirements
- R1: While `rst_ni` is low, `valid_o` and `data_o` are zero.
- R2: When `os_en_i` stays high, `valid_o` is high on exactly one cycle in every five. The pulse follows the edge that captures the fifth word of a group.
- R3: With lane width W = 10·SYM_PER_CLK, lane bit p·(W/5)+j of a completed word equals input bit 5j+2 of the word captured at phase p (p = 0..4, j = 0..W/5−1). This places bits LSB first, in the order they arrive.
- R4: Input samples at positions 5j, 5j+1, 5j+3 and 5j+4 have no effect on `data_o`.
- R5: In oversampled mode, `data_o` keeps its value on every cycle that carries no pulse.
- R6: When `os_en_i` is low, the next cycle has `valid_o` high and `data_o` equal to the word presented on the previous cycle.
- R7: After a switch from bypass to oversampled mode, the first pulse comes after the fifth oversampled word, counting the first word captured with `os_en_i` high.
- R8: Leaving oversampled mode in the middle of a group drops the partial group. The next oversampled group starts again at phase 0.
- R9: Each lane occupies bits [c·W +: W] of `data_i` and `data_o`, and lanes do not affect one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transceiver parallel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| os_en_i | input | 1 | 1: oversampled extraction, 0: bypass |
| data_i | input | NUM_CH·SYM_PER_CLK·10 | Transceiver words, lane c in slice c |
| data_o | output | NUM_CH·SYM_PER_CLK·10 | Recovered or bypassed words |
| valid_o | output | 1 | FIFO write request |

## Verification
A single bit is walked across every lane bit position. A design that swapped the phase slices, reversed the bit order inside a slice, or leaked one lane into another would put that bit in the wrong place. Random groups are driven with random or inverted non-centre samples. These catch a design that reads an off-centre sample or votes across the group. The mode is switched in both directions, including in the middle of a group. A phase counter that is not cleared would emit its first pulse early, or would mix stale bits into the next word. Every non-pulse cycle is also checked for output stability, which exposes an output register that tracks the accumulator as it fills.

// File: rtl/osx_pkg.sv
package osx_pkg;
  localparam int unsigned OSR     = 5;
  localparam int unsigned CENTRE  = 2;
  localparam int unsigned PHASE_W = $clog2(OSR);
  typedef logic [PHASE_W-1:0] phase_t;
endpackage

// File: rtl/osx_phase_ctr.sv
module osx_phase_ctr
  import osx_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   run_i,
  output phase_t phase_o,
  output logic   last_o
);
  phase_t phase_q;

  // held at zero outside oversampled mode, so a mode change restarts the group
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             phase_q <= '0;
    else if (!run_i)                         phase_q <= '0;
    else if (phase_q == phase_t'(OSR - 1))   phase_q <= '0;
    else                                     phase_q <= phase_q + 1'b1;
  end

  assign phase_o = phase_q;
  assign last_o  = run_i && (phase_q == phase_t'(OSR - 1));
endmodule

// File: rtl/osx_lane_pack.sv
module osx_lane_pack
  import osx_pkg::*;
#(
  parameter int unsigned LANE_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  phase_t            phase_i,
  input  logic              last_i,
  input  logic [LANE_W-1:0] raw_i,
  output logic [LANE_W-1:0] data_o
);
  localparam int unsigned BPW = LANE_W / OSR;

  logic [BPW-1:0]    pick;
  logic [LANE_W-1:0] acc_q, merged, data_q;

  for (genvar j = 0; j < BPW; j++) begin : g_pick
    assign pick[j] = raw_i[j*OSR + CENTRE];
  end

  for (genvar k = 0; k < OSR; k++) begin : g_slot
    assign merged[k*BPW +: BPW] = (phase_i == phase_t'(k)) ? pick : acc_q[k*BPW +: BPW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      data_q <= '0;
    end else begin
      if (run_i) acc_q <= merged;
      if (!run_i)      data_q <= raw_i;
      else if (last_i) data_q <= merged;
    end
  end

  assign data_o = data_q;
endmodule

// File: rtl/osx_extract.sv
module osx_extract
  import osx_pkg::*;
#(
  parameter int unsigned SYM_PER_CLK = 2,
  parameter int unsigned NUM_CH      = 3
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            os_en_i,
  input  logic [NUM_CH*SYM_PER_CLK*10-1:0] data_i,
  output logic [NUM_CH*SYM_PER_CLK*10-1:0] data_o,
  output logic                            valid_o
);
  localparam int unsigned LANE_W = SYM_PER_CLK * 10;

  phase_t phase;
  logic   last;
  logic   valid_q;

  osx_phase_ctr u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (os_en_i),
    .phase_o (phase),
    .last_o  (last)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    osx_lane_pack #(.LANE_W(LANE_W)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (os_en_i),
      .phase_i (phase),
      .last_i  (last),
      .raw_i   (data_i[c*LANE_W +: LANE_W]),
      .data_o  (data_o[c*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= !os_en_i || last;
  end

  assign valid_o = valid_q;
endmodule

// File: rtl/osx_extract_chk.sv
module osx_extract_chk #(
  parameter int unsigned BUS_W = 60
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             os_en_i,
  input logic [BUS_W-1:0] data_i,
  input logic [BUS_W-1:0] data_o,
  input logic             valid_o
);
  logic [2:0] run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              run_cnt <= '0;
    else if (!os_en_i)        run_cnt <= '0;
    else if (run_cnt == 3'd4) run_cnt <= '0;
    else                      run_cnt <= run_cnt + 3'd1;
  end

  // R2
  pulse_on_fifth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (os_en_i && run_cnt == 3'd4) |=> valid_o);

  // R2
  single_cycle_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (os_en_i && valid_o) |=> !valid_o);

  // R5
  hold_between_pulses_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (os_en_i && run_cnt != 3'd4) |=> (!valid_o && $stable(data_o)));

  // R6
  bypass_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !os_en_i |=> (valid_o && data_o == $past(data_i)));
endmodule

bind osx_extract osx_extract_chk #(.BUS_W(NUM_CH*SYM_PER_CLK*10)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .os_en_i (os_en_i),
  .data_i  (data_i),
  .data_o  (data_o),
  .valid_o (valid_o)
);

// File: tb/osx_extract_tb.sv
module osx_extract_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SYM = 2;
  localparam int NCH = 3;
  localparam int LW  = SYM * 10;
  localparam int BW  = NCH * LW;
  localparam int BPW = LW / 5;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          os_en_i;
  logic [BW-1:0] data_i;
  logic [BW-1:0] data_o;
  logic          valid_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [BW-1:0] last_out;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  osx_extract #(.SYM_PER_CLK(SYM), .NUM_CH(NCH)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .os_en_i(os_en_i),
    .data_i(data_i), .data_o(data_o), .valid_o(valid_o)
  );

  task automatic chk_vec(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: data_o actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: valid_o actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] rnd_bus();
    return BW'({$urandom(), $urandom()});
  endfunction

  // noise 0: clean, 1: off-centre inverted, 2: off-centre random
  function automatic logic [BW-1:0] build_word(input logic [BW-1:0] bits, input int p, input int noise);
    logic [BW-1:0] w = '0;
    for (int c = 0; c < NCH; c++)
      for (int j = 0; j < BPW; j++) begin
        logic b = bits[c*LW + p*BPW + j];
        for (int s = 0; s < 5; s++) begin
          logic v;
          if (s == 2 || noise == 0) v = b;
          else if (noise == 1)      v = ~b;
          else                      v = 1'($urandom_range(0, 1));
          w[c*LW + j*5 + s] = v;
        end
      end
    return w;
  endfunction

  // drive at negedge, return just after the capturing posedge
  task automatic drive_word(input logic [BW-1:0] d, input logic en);
    @(negedge clk_i);
    data_i  = d;
    os_en_i = en;
    #(CLK_PERIOD/2 + 1);
  endtask

  task automatic run_group(input logic [BW-1:0] bits, input int noise, input string req);
    for (int p = 0; p < 5; p++) begin
      drive_word(build_word(bits, p, noise), 1'b1);
      if (p < 4) begin
        chk_bit("R2", valid_o, 1'b0);
        chk_vec("R5", data_o, last_out);
      end else begin
        chk_bit("R2", valid_o, 1'b1);
        chk_vec(req, data_o, bits);
        last_out = bits;
      end
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0; os_en_i = 1'b0; data_i = '0;
    repeat (3) @(posedge clk_i);
    #1;
    chk_bit("R1", valid_o, 1'b0);
    chk_vec("R1", data_o, '0);
    data_i = rnd_bus();
    #1;
    chk_vec("R1", data_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R6 bypass
    for (int i = 0; i < 20; i++) begin
      logic [BW-1:0] d = rnd_bus();
      drive_word(d, 1'b0);
      chk_bit("R6", valid_o, 1'b1);
      chk_vec("R6", data_o, d);
      last_out = d;
    end

    // R7 first group after switch-over; R9 walking bit over all lanes
    run_group(BW'(1), 0, "R7");
    for (int i = 1; i < BW; i++) run_group(BW'(1) << i, 0, "R9");
    for (int i = 0; i < BW; i++) run_group(~(BW'(1) << i), 0, "R3");
    run_group('0, 0, "R3");
    run_group('1, 0, "R3");

    // R4 off-centre samples ignored
    for (int i = 0; i < 10; i++) run_group(rnd_bus(), 1, "R4");
    for (int i = 0; i < 40; i++) run_group(rnd_bus(), 2, "R4");

    // R8 abort mid-group, bypass, resume
    for (int a = 1; a < 5; a++) begin
      logic [BW-1:0] junk = rnd_bus();
      for (int p = 0; p < a; p++) begin
        drive_word(build_word(junk, p, 0), 1'b1);
        chk_bit("R8", valid_o, 1'b0);
        chk_vec("R8", data_o, last_out);
      end
      for (int i = 0; i < 2; i++) begin
        logic [BW-1:0] d = rnd_bus();
        drive_word(d, 1'b0);
        chk_bit("R6", valid_o, 1'b1);
        chk_vec("R6", data_o, d);
        last_out = d;
      end
      run_group(rnd_bus(), 2, "R8");
    end

    finish_run();
  end
endmodule